// File: doc/BRIEF.md
# Data Object Mailbox Responder

This block is the device side of a dword-wide mailbox. A host reaches it through four word registers: a control register, a status register, a write-data register and a read-data register. The host pushes a request object one dword at a time into the write-data register and then sets the go bit. The block validates the two header dwords against the one service it hosts, an echo service. If the header is valid it copies the object into a separate response buffer, one dword per clock, and holds busy while it does so. It then raises the ready flag.

The host drains the response through the read-data register. A read returns the current dword, and any write to that register acknowledges the dword and moves to the next. The ready flag drops once the last dword has been acknowledged. A malformed or unsupported request sets a sticky error flag and produces no response. One abort command brings the mailbox back to its empty, idle state from any condition, with busy, error and ready all clear.

Top module: `mbx_responder`

## Requirements
- R1: Header dword 0 holds the vendor ID in bits [15:0] and the object type in bits [23:16]. A go for a request whose pair differs from the hosted pair (parameters VENDOR_ID, OBJ_TYPE) sets error and produces no response.
- R2: The object length is the low 18 bits of header dword 1 and counts both header dwords. Bits above bit 17 are ignored. A length below 2 sets error on go.
- R3: A go with fewer than 2 dwords written, or with a dword count that differs from the length field, sets error and produces no response.
- R4: The request buffer holds DEPTH dwords. A write to the write-data register with the buffer full is dropped and sets error.
- R5: An accepted go raises busy at the next edge. Busy then holds for exactly L cycles, where L is the object length. It falls in the same edge that raises ready, and the response is an exact echo of the request.
- R6: While ready is set, the read-data register returns response dword k, starting at k=0. Each write to the read-data register advances k, and ready clears when the write acknowledging dword L-1 lands.
- R7: The read-data register reads as zero while ready is clear, and a write to it then has no effect.
- R8: A control write with the abort bit (bit 1) set clears busy, error and ready at the next edge and empties the request buffer, from any state. Abort wins over go in the same write. Error otherwise stays set until an abort.
- R9: While busy, go and write-data writes are ignored. While error is set, go is ignored.
- R10: Register addresses are 0 control (bit 0 go, bit 1 abort), 1 status (bit 0 busy, bit 1 error, bit 2 ready, others zero), 2 write-data and 3 read-data. The control and write-data registers read as zero.
- R11: After reset, busy, error and ready are clear and the request buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address, used for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the addressed register, combinational |

## Verification
A wrong counter or flag inside the block shows at the status or read-data register within one clock, because the bench reads one of them after every edge and compares it with a behavioural model. A copy pointer that is off by one appears as a busy window of the wrong length, or as a wrong echoed dword, when the response is drained. A missed clear on abort appears as error or ready still set on the very next status read. A dropped advance on acknowledge shows as the same dword returned twice, one cycle after the acknowledge.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_WDATA = 2'd2,
    ADDR_RDATA = 2'd3
  } regAddr_e;

  localparam int GO_BIT     = 0;
  localparam int ABORT_BIT  = 1;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_ERR   = 1;
  localparam int STAT_READY = 2;
  localparam int LEN_W      = 18;
  localparam int VEND_W     = 16;
  localparam int TYPE_W     = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic reqPush;  // store write data into the request buffer
    logic rspCopy;  // move one dword from request to response buffer
  } dpStrobe_t;

endpackage

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter logic [VEND_W-1:0] VENDOR_ID = 16'hB2C4,
  parameter logic [TYPE_W-1:0] OBJ_TYPE  = 8'h01,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [1:0]        ctrlBits,
  input  logic [VEND_W-1:0] hdrVend,
  input  logic [TYPE_W-1:0] hdrType,
  input  logic [LEN_W-1:0]  hdrLen,
  output dpStrobe_t         strobe,
  output logic [IW-1:0]     pushIdx,
  output logic [IW-1:0]     copyIdx,
  output logic [IW-1:0]     rdIdx,
  output logic              busy,
  output logic              err,
  output logic              ready
);

  logic          busyQ, errQ, readyQ;
  logic [CW-1:0] wrCnt, copyCnt, rspLen, rdCnt;

  logic ctrlWr, abortCmd, goCmd, dataWr, ackWr;
  logic bufFull, hdrOk, lenOk, reqValid;

  always_comb begin
    ctrlWr   = regWr && (regAddr == ADDR_CTRL);
    abortCmd = ctrlWr && ctrlBits[ABORT_BIT];
    goCmd    = ctrlWr && ctrlBits[GO_BIT] && !ctrlBits[ABORT_BIT];
    dataWr   = regWr && (regAddr == ADDR_WDATA);
    ackWr    = regWr && (regAddr == ADDR_RDATA);
    bufFull  = (wrCnt == CW'(DEPTH));
    hdrOk    = (hdrVend == VENDOR_ID) && (hdrType == OBJ_TYPE);
    lenOk    = (hdrLen >= LEN_W'(2)) && (32'(hdrLen) == 32'(wrCnt));
    reqValid = (wrCnt >= CW'(2)) && hdrOk && lenOk;
  end

  always_comb begin
    strobe.reqPush = dataWr && !busyQ && !bufFull;
    strobe.rspCopy = busyQ && !abortCmd;
    pushIdx = wrCnt[IW-1:0];
    copyIdx = copyCnt[IW-1:0];
    rdIdx   = rdCnt[IW-1:0];
    busy    = busyQ;
    err     = errQ;
    ready   = readyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || abortCmd) begin
      busyQ   <= 1'b0;
      errQ    <= 1'b0;
      readyQ  <= 1'b0;
      wrCnt   <= '0;
      copyCnt <= '0;
      rspLen  <= '0;
      rdCnt   <= '0;
    end else if (busyQ) begin
      if (copyCnt == rspLen - CW'(1)) begin
        busyQ  <= 1'b0;
        readyQ <= 1'b1;
        rdCnt  <= '0;
      end else begin
        copyCnt <= copyCnt + CW'(1);
      end
    end else if (dataWr) begin
      if (bufFull) errQ  <= 1'b1;
      else         wrCnt <= wrCnt + CW'(1);
    end else if (ackWr && readyQ) begin
      if (rdCnt == rspLen - CW'(1)) readyQ <= 1'b0;
      rdCnt <= rdCnt + CW'(1);
    end else if (goCmd && !errQ) begin
      wrCnt <= '0;
      if (reqValid) begin
        busyQ   <= 1'b1;
        readyQ  <= 1'b0;
        copyCnt <= '0;
        rspLen  <= wrCnt;
      end else begin
        errQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mbx_data.sv
`timescale 1ns/1ps
module mbx_data
  import mbx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  dpStrobe_t         strobe,
  input  logic [IW-1:0]     pushIdx,
  input  logic [IW-1:0]     copyIdx,
  input  logic [IW-1:0]     rdIdx,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic              busy,
  input  logic              err,
  input  logic              ready,
  output logic [VEND_W-1:0] hdrVend,
  output logic [TYPE_W-1:0] hdrType,
  output logic [LEN_W-1:0]  hdrLen,
  output logic [31:0]       regRdData
);

  logic [31:0] reqMem [DEPTH];
  logic [31:0] rspMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.reqPush) reqMem[pushIdx] <= regWrData;
    if (strobe.rspCopy) rspMem[copyIdx] <= reqMem[copyIdx];
  end

  // header fields for validation by the control side
  logic [31:0] hdrWord0, hdrWord1;
  always_comb begin
    hdrWord0 = reqMem[0];
    hdrWord1 = reqMem[IW'(1)];
    hdrVend  = hdrWord0[VEND_W-1:0];
    hdrType  = hdrWord0[VEND_W +: TYPE_W];
    hdrLen   = hdrWord1[LEN_W-1:0];
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_STAT: begin
        regRdData[STAT_BUSY]  = busy;
        regRdData[STAT_ERR]   = err;
        regRdData[STAT_READY] = ready;
      end
      ADDR_RDATA: if (ready) regRdData = rspMem[rdIdx];
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/mbx_responder.sv
`timescale 1ns/1ps
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter logic [VEND_W-1:0] VENDOR_ID = 16'hB2C4,
  parameter logic [TYPE_W-1:0] OBJ_TYPE  = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  dpStrobe_t         strobe;
  logic [IW-1:0]     pushIdx, copyIdx, rdIdx;
  logic              busy, err, ready;
  logic [VEND_W-1:0] hdrVend;
  logic [TYPE_W-1:0] hdrType;
  logic [LEN_W-1:0]  hdrLen;

  mbx_ctrl #(.DEPTH(DEPTH), .VENDOR_ID(VENDOR_ID), .OBJ_TYPE(OBJ_TYPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .ctrlBits(regWrData[1:0]), .hdrVend(hdrVend), .hdrType(hdrType), .hdrLen(hdrLen),
    .strobe(strobe), .pushIdx(pushIdx), .copyIdx(copyIdx), .rdIdx(rdIdx),
    .busy(busy), .err(err), .ready(ready)
  );

  mbx_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .strobe(strobe), .pushIdx(pushIdx), .copyIdx(copyIdx), .rdIdx(rdIdx),
    .regAddr(regAddr), .regWrData(regWrData), .busy(busy), .err(err), .ready(ready),
    .hdrVend(hdrVend), .hdrType(hdrType), .hdrLen(hdrLen), .regRdData(regRdData)
  );

endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        busy,
  input logic        err,
  input logic        ready
);

  logic abortWr, goWr;
  assign abortWr = regWr && (regAddr == 2'd0) && regWrData[1];
  assign goWr    = regWr && (regAddr == 2'd0) && regWrData[0];

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    abortWr |=> (!busy && !err && !ready)); // R8

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (err && !abortWr) |=> err); // R8

  AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && ready)); // R5

  AST_BUSY_FROM_GO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(goWr && !abortWr)); // R5

  AST_READY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(abortWr)) |-> ready); // R5

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr == 2'd3) && !ready) |-> (regRdData == 32'd0)); // R7

endmodule

bind mbx_responder mbx_checker u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
  .regRdData(regRdData), .busy(busy), .err(err), .ready(ready)
);

// File: tb/test_mbx_responder.sv
`timescale 1ns/1ps
module test_mbx_responder;

  localparam int DEPTH = 64;
  localparam logic [15:0] VEND = 16'hB2C4;
  localparam logic [7:0]  TYP  = 8'h01;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd1;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  always #2.5 clk = ~clk;

  mbx_responder #(.DEPTH(DEPTH), .VENDOR_ID(VEND), .OBJ_TYPE(TYP)) i_mbx_responder (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  int vecs = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R11";

  // behavioural model
  logic [31:0] reqQ[$];
  logic [31:0] pendQ[$];
  logic [31:0] rspQ[$];
  bit mBusy = 0, mErr = 0, mReady = 0;
  int mBusyCnt = 0, mRdIdx = 0;

  function automatic logic [31:0] expRead(logic [1:0] a);
    case (a)
      2'd1: return {29'd0, mReady, mErr, mBusy};
      2'd3: return mReady ? rspQ[mRdIdx] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic modelEdge(bit wr, logic [1:0] a, logic [31:0] d);
    bit abortC = wr && a == 2'd0 && d[1];
    bit goC    = wr && a == 2'd0 && d[0] && !abortC;
    if (abortC) begin
      reqQ.delete(); mBusy = 0; mErr = 0; mReady = 0;
    end else if (mBusy) begin
      mBusyCnt--;
      if (mBusyCnt == 0) begin
        mBusy = 0; mReady = 1; mRdIdx = 0; rspQ = pendQ;
      end
    end else if (wr && a == 2'd2) begin
      if (reqQ.size() == DEPTH) mErr = 1;
      else reqQ.push_back(d);
    end else if (wr && a == 2'd3 && mReady) begin
      mRdIdx++;
      if (mRdIdx == rspQ.size()) mReady = 0;
    end else if (goC && !mErr) begin
      int n = reqQ.size();
      bit ok = 0;
      if (n >= 2) begin
        int len = int'(reqQ[1] & 32'h3FFFF);
        ok = reqQ[0][15:0] == VEND && reqQ[0][23:16] == TYP && len >= 2 && len == n;
      end
      if (ok) begin
        pendQ = reqQ; mBusy = 1; mBusyCnt = n; mReady = 0;
      end else mErr = 1;
      reqQ.delete();
    end
  endtask

  task automatic step(bit wr, logic [1:0] a, logic [31:0] d);
    logic [31:0] e;
    regWr = wr; regAddr = a; regWrData = d;
    @(posedge clk);
    modelEdge(wr, a, d);
    @(negedge clk);
    e = expRead(a);
    vecs++;
    if (regRdData !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", curReq, a, regRdData, e);
    end
  endtask

  // hand-computed check independent of the model
  task automatic handCheck(logic [1:0] a, logic [31:0] e, string tag);
    step(1'b0, a, 32'd0);
    vecs++;
    if (regRdData !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, regRdData, e);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd1, 32'd0);
  endtask

  task automatic pushObj(logic [31:0] h0, logic [31:0] h1, int total);
    step(1'b1, 2'd2, h0);
    if (total > 1) step(1'b1, 2'd2, h1);
    for (int i = 2; i < total; i++) step(1'b1, 2'd2, 32'h5A00_0000 ^ (i * 32'h0101_0307));
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 2'd3, 32'd0);
      step(1'b1, 2'd3, 32'd0);
    end
  endtask

  task automatic goCmd();    step(1'b1, 2'd0, 32'd1); endtask
  task automatic abortCmd(); step(1'b1, 2'd0, 32'd2); endtask

  logic [31:0] hOk;

  initial begin
    hOk = {8'h00, TYP, VEND};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R11"; handCheck(2'd1, 32'd0, "R11");
    curReq = "R10"; handCheck(2'd0, 32'd0, "R10"); handCheck(2'd2, 32'd0, "R10");
    curReq = "R7";  handCheck(2'd3, 32'd0, "R7"); step(1'b1, 2'd3, 32'd0); idle(1);

    curReq = "R5";  pushObj(hOk, 32'd4, 4); goCmd();
    handCheck(2'd1, 32'd1, "R5"); idle(4);
    curReq = "R6";  handCheck(2'd3, hOk, "R6"); drain(4); idle(1);

    curReq = "R5";  pushObj(hOk, 32'd2, 2); goCmd(); idle(3);
    curReq = "R6";  drain(2);

    curReq = "R2";  pushObj(hOk, 32'hFFFC_0003, 3); goCmd(); idle(4); drain(3);
    pushObj(hOk, 32'd1, 2); goCmd(); handCheck(2'd1, 32'd2, "R2"); abortCmd();

    curReq = "R1";  pushObj({8'h00, TYP, VEND ^ 16'h0001}, 32'd2, 2); goCmd();
    handCheck(2'd1, 32'd2, "R1"); abortCmd();
    pushObj({8'h00, TYP ^ 8'h80, VEND}, 32'd3, 3); goCmd(); handCheck(2'd3, 32'd0, "R1"); abortCmd();

    curReq = "R3";  pushObj(hOk, 32'd5, 4); goCmd(); handCheck(2'd1, 32'd2, "R3"); abortCmd();
    pushObj(hOk, 32'd3, 4); goCmd(); abortCmd();
    step(1'b1, 2'd2, hOk); goCmd(); abortCmd();

    curReq = "R9";  pushObj(hOk, 32'd1, 2); goCmd();
    pushObj(hOk, 32'd2, 2); goCmd(); handCheck(2'd1, 32'd2, "R9"); abortCmd();
    pushObj(hOk, 32'd6, 6); goCmd();
    step(1'b1, 2'd2, 32'hDEAD_BEEF); goCmd(); idle(5); drain(6);
    pushObj(hOk, 32'd2, 2); goCmd(); idle(3); drain(2);

    curReq = "R4";  pushObj(hOk, 32'd64, 65); handCheck(2'd1, 32'd2, "R4"); abortCmd();
    pushObj(hOk, 32'd64, 64); goCmd(); idle(66); drain(64);

    curReq = "R8";  pushObj(hOk, 32'd8, 8); goCmd(); idle(3); abortCmd();
    handCheck(2'd1, 32'd0, "R8");
    pushObj(hOk, 32'd4, 4); goCmd(); idle(5); drain(2); abortCmd();
    handCheck(2'd3, 32'd0, "R8");
    pushObj(hOk, 32'd2, 2); step(1'b1, 2'd0, 32'd3); idle(2);
    goCmd(); handCheck(2'd1, 32'd2, "R8"); abortCmd(); idle(2);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule